// File: doc/BRIEF.md
# DMA Channel Transfer Sequencer

This block holds the address and count state for a single DMA channel. Software programs a start source address, a start destination address, a 16-bit transfer count and a control word through a small register write port. An outside requester or arbiter then pulses a strobe once per completed bus transfer. On each strobe the block steps the channel by one transfer. It presents the addresses for the next transfer, the remaining count, a busy flag and a sticky completion interrupt request. The bus cycles, arbitration and request-source selection live outside the block.

Two modes are supported. In normal mode a loaded count of N gives N+1 transfers. The channel stops itself when the count steps from 0 to H'FFFF and raises a completion request, which a mask bit can suppress. In ring mode the count runs freely and the channel never stops by itself. Every incrementing address returns to its start value after 32 transfers, and no completion request is produced. Each address can be fixed or incrementing, and the transfer size is 8 or 16 bits.

Top module: `dma_chan_seq`

## Requirements
- R1: After reset, both addresses and the count are 0, and `busy` and `irq_req` are 0.
- R2: A write with `wr_sel` = 0 loads the source address, 1 loads the destination address, and 2 loads the count from `wr_data[15:0]`. A write with `wr_sel` = 3 loads the control word, whose bits are: bit0 enable, bit1 ring mode, bit2 16-bit size, bit3 source increment, bit4 destination increment, bit5 interrupt mask. A 0-to-1 change of enable captures the current addresses as the ring start values and zeroes the ring position.
- R3: A strobe has no effect on any address or on the count when it arrives while enable is 0. It also has no effect when it arrives in the same cycle as a write with `wr_sel` from 0 to 3.
- R4: On an accepted strobe, an incrementing address advances by 1 for 8-bit size and by 2 for 16-bit size. A fixed address keeps its programmed value.
- R5: Each accepted strobe decrements the count by 1, modulo 2^16. A loaded count of N yields N+1 transfers in normal mode. Re-enabling with a count of H'FFFF, without reloading it, yields 65,536 transfers.
- R6: In normal mode, the transfer that moves the count from 0 to H'FFFF clears enable (`busy` = 0). Each incrementing address is then left at the last transfer address plus the step.
- R7: A normal-mode completion sets the sticky `irq_req` unless the mask bit is 1. A write with `wr_sel` = 4 and `wr_data[0]` = 1 clears the request. The mask never sets the request and never holds it set.
- R8: In ring mode, an incrementing address reaches start + 31×step and then returns to its start value on the 32nd transfer. The count passes through 0 without stopping the channel.
- R9: Ring mode never raises `irq_req`. This includes the case where software ends the transfer by writing enable = 0.
- R10: When a normal-mode completion and an interrupt-clear write fall in the same cycle, the request ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 3 | Register select (0 src, 1 dst, 2 count, 3 control, 4 irq clear) |
| wr_data | input | 32 | Write data |
| xfer_stb | input | 1 | One pulse per completed transfer |
| src_addr | output | 32 | Source address of the next transfer |
| dst_addr | output | 32 | Destination address of the next transfer |
| xfer_count | output | 16 | Current transfer count |
| busy | output | 1 | Channel enable state |
| irq_req | output | 1 | Sticky completion interrupt request |

## Verification
Two pairs of functions can land in the same cycle. The first pair is the final normal-mode strobe and a software write of the interrupt clear. The bench raises both inputs in one cycle and expects the request to be set afterwards. The second pair is a strobe and a configuration write. The bench pulses a strobe together with a count write, then expects the written count to appear and both addresses to stay unchanged.

// File: rtl/dma_seq_pkg.sv
package dma_seq_pkg;

  // register select codes of the write port
  localparam logic [2:0] SEL_SRC  = 3'd0;
  localparam logic [2:0] SEL_DST  = 3'd1;
  localparam logic [2:0] SEL_CNT  = 3'd2;
  localparam logic [2:0] SEL_CTRL = 3'd3;
  localparam logic [2:0] SEL_IRQ  = 3'd4;

  // control word bit positions
  localparam int CTL_EN   = 0;
  localparam int CTL_RING = 1;
  localparam int CTL_SZ16 = 2;
  localparam int CTL_SINC = 3;
  localparam int CTL_DINC = 4;
  localparam int CTL_MASK = 5;

  typedef struct packed {
    logic mask;
    logic dst_inc;
    logic src_inc;
    logic size16;
    logic ring;
  } chan_cfg_t;

  // bytes moved per transfer
  function automatic logic [1:0] addr_step(input logic size16);
    return size16 ? 2'd2 : 2'd1;
  endfunction

  function automatic logic is_cfg_sel(input logic [2:0] sel);
    return sel <= SEL_CTRL;
  endfunction

endpackage

// File: rtl/dma_ctrl_reg.sv
module dma_ctrl_reg
  import dma_seq_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ctl_wr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              last_xfer,
  output chan_cfg_t         cfg,
  output logic              enable,
  output logic              en_rise
);

  assign en_rise = ctl_wr && wr_data[CTL_EN] && !enable;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg    <= '0;
      enable <= 1'b0;
    end else if (ctl_wr) begin
      enable      <= wr_data[CTL_EN];
      cfg.ring    <= wr_data[CTL_RING];
      cfg.size16  <= wr_data[CTL_SZ16];
      cfg.src_inc <= wr_data[CTL_SINC];
      cfg.dst_inc <= wr_data[CTL_DINC];
      cfg.mask    <= wr_data[CTL_MASK];
    end else if (last_xfer) begin
      enable <= 1'b0;
    end
  end

endmodule

// File: rtl/dma_addr_chan.sv
module dma_addr_chan
  import dma_seq_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [ADDR_W-1:0] wr_data,
  input  logic              capture,
  input  logic              advance,
  input  logic              inc,
  input  logic              size16,
  input  logic              wrap,
  output logic [ADDR_W-1:0] addr
);

  logic [ADDR_W-1:0] start_q;
  logic [ADDR_W-1:0] step;

  assign step = {{(ADDR_W-2){1'b0}}, addr_step(size16)};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr <= '0;
    end else if (load) begin
      addr <= wr_data;
    end else if (advance && inc) begin
      addr <= wrap ? start_q : addr + step;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      start_q <= '0;
    end else if (capture) begin
      start_q <= addr;
    end
  end

endmodule

// File: rtl/dma_xfer_count.sv
module dma_xfer_count #(
  parameter int CNT_W = 16,
  parameter int POS_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] wr_data,
  input  logic             restart,
  input  logic             advance,
  output logic [CNT_W-1:0] count,
  output logic             cnt_zero,
  output logic             pos_last
);

  logic [POS_W-1:0] pos;

  assign cnt_zero = (count == '0);
  assign pos_last = &pos;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count <= '0;
    end else if (load) begin
      count <= wr_data;
    end else if (advance) begin
      count <= count - CNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pos <= '0;
    end else if (restart) begin
      pos <= '0;
    end else if (advance) begin
      pos <= pos + POS_W'(1);
    end
  end

endmodule

// File: rtl/dma_chan_seq.sv
module dma_chan_seq
  import dma_seq_pkg::*;
#(
  parameter int ADDR_W   = 32,
  parameter int CNT_W    = 16,
  parameter int RING_LOG = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [2:0]        wr_sel,
  input  logic [ADDR_W-1:0] wr_data,
  input  logic              xfer_stb,
  output logic [ADDR_W-1:0] src_addr,
  output logic [ADDR_W-1:0] dst_addr,
  output logic [CNT_W-1:0]  xfer_count,
  output logic              busy,
  output logic              irq_req
);

  localparam int N_ADDR = 2;

  chan_cfg_t cfg;
  logic      enable, en_rise;
  logic      cfg_wr, ctl_wr, cnt_wr;
  logic      xfer_go, last_xfer, ring_wrap;
  logic      irq_set, irq_clr;
  logic      cnt_zero, pos_last;
  logic [ADDR_W-1:0] addr_q [N_ADDR];

  assign cfg_wr    = wr_en && is_cfg_sel(wr_sel);
  assign ctl_wr    = wr_en && (wr_sel == SEL_CTRL);
  assign cnt_wr    = wr_en && (wr_sel == SEL_CNT);
  assign xfer_go   = xfer_stb && enable && !cfg_wr;
  assign last_xfer = xfer_go && !cfg.ring && cnt_zero;
  assign ring_wrap = cfg.ring && pos_last;
  assign irq_set   = last_xfer && !cfg.mask;
  assign irq_clr   = wr_en && (wr_sel == SEL_IRQ) && wr_data[0];

  dma_ctrl_reg #(.DATA_W(ADDR_W)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .ctl_wr    (ctl_wr),
    .wr_data   (wr_data),
    .last_xfer (last_xfer),
    .cfg       (cfg),
    .enable    (enable),
    .en_rise   (en_rise)
  );

  dma_xfer_count #(.CNT_W(CNT_W), .POS_W(RING_LOG)) u_count (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (cnt_wr),
    .wr_data  (wr_data[CNT_W-1:0]),
    .restart  (en_rise),
    .advance  (xfer_go),
    .count    (xfer_count),
    .cnt_zero (cnt_zero),
    .pos_last (pos_last)
  );

  for (genvar g = 0; g < N_ADDR; g++) begin : g_addr
    logic ld, inc;
    assign ld  = wr_en && (wr_sel == ((g == 0) ? SEL_SRC : SEL_DST));
    assign inc = (g == 0) ? cfg.src_inc : cfg.dst_inc;
    dma_addr_chan #(.ADDR_W(ADDR_W)) u_addr (
      .clk     (clk),
      .rst_n   (rst_n),
      .load    (ld),
      .wr_data (wr_data),
      .capture (en_rise),
      .advance (xfer_go),
      .inc     (inc),
      .size16  (cfg.size16),
      .wrap    (ring_wrap),
      .addr    (addr_q[g])
    );
  end

  assign src_addr = addr_q[0];
  assign dst_addr = addr_q[1];
  assign busy     = enable;

  // set has priority over a same-cycle clear
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_req <= 1'b0;
    end else if (irq_set) begin
      irq_req <= 1'b1;
    end else if (irq_clr) begin
      irq_req <= 1'b0;
    end
  end

endmodule

// File: rtl/dma_chan_seq_chk.sv
module dma_chan_seq_chk #(
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              xfer_stb,
  input logic              wr_en,
  input logic              busy,
  input logic              irq_req,
  input logic [ADDR_W-1:0] src_addr,
  input logic [ADDR_W-1:0] dst_addr,
  input logic [CNT_W-1:0]  xfer_count,
  input logic              xfer_go,
  input logic              last_xfer,
  input logic              ring,
  input logic              mask,
  input logic              src_inc,
  input logic              dst_inc
);

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && xfer_stb && !wr_en) |=> ($stable(src_addr) && $stable(dst_addr) && $stable(xfer_count))); // R3

  AST_FIXED_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_go && !src_inc && !dst_inc) |=> ($stable(src_addr) && $stable(dst_addr))); // R4

  AST_COUNT_DEC: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_go |=> (xfer_count == $past(xfer_count) - CNT_W'(1))); // R5

  AST_DONE_STOP: assert property (@(posedge clk) disable iff (!rst_n)
    last_xfer |=> !busy); // R6

  AST_IRQ_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_req) |-> ($past(last_xfer) && !$past(mask))); // R7

  AST_RING_RUNS: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_go && ring) |=> busy); // R8

  AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (last_xfer && !mask) |=> irq_req); // R10

endmodule

bind dma_chan_seq dma_chan_seq_chk #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .xfer_stb   (xfer_stb),
  .wr_en      (wr_en),
  .busy       (busy),
  .irq_req    (irq_req),
  .src_addr   (src_addr),
  .dst_addr   (dst_addr),
  .xfer_count (xfer_count),
  .xfer_go    (xfer_go),
  .last_xfer  (last_xfer),
  .ring       (cfg.ring),
  .mask       (cfg.mask),
  .src_inc    (cfg.src_inc),
  .dst_inc    (cfg.dst_inc)
);

// File: tb/test_dma_chan_seq.sv
module test_dma_chan_seq;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_sel = '0;
  logic [31:0] wr_data = '0;
  logic        xfer_stb = 1'b0;
  logic [31:0] src_addr, dst_addr;
  logic [15:0] xfer_count;
  logic        busy, irq_req;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dma_chan_seq i_dma_chan_seq (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .xfer_stb(xfer_stb), .src_addr(src_addr), .dst_addr(dst_addr),
    .xfer_count(xfer_count), .busy(busy), .irq_req(irq_req)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic cyc();
    @(posedge clk);
    #1;
  endtask

  task automatic wr(input logic [2:0] sel, input logic [31:0] d);
    wr_en = 1'b1; wr_sel = sel; wr_data = d;
    cyc();
    wr_en = 1'b0;
  endtask

  task automatic stb();
    xfer_stb = 1'b1;
    cyc();
    xfer_stb = 1'b0;
  endtask

  function automatic logic [31:0] ctl(input bit en, input bit ring, input bit sz, input bit si, input bit di, input bit m);
    return {26'd0, m, di, si, sz, ring, en};
  endfunction

  initial begin
    #(CLK_PERIOD * 190000);
    n_fail++;
    $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] s0, d0, es, ed;
    int step, ntx;
    cyc(); cyc();
    rst_n = 1'b1;
    cyc();
    // R1 reset state
    chk(src_addr == 0 && dst_addr == 0, "R1 addr", src_addr, 0);
    chk(xfer_count == 0, "R1 count", {16'd0, xfer_count}, 0);
    chk(!busy && !irq_req, "R1 flags", {30'd0, busy, irq_req}, 0);

    // R3 strobe while disabled
    wr(3'd0, 32'h0000_4000);
    stb();
    chk(src_addr == 32'h4000 && xfer_count == 0, "R3 idle strobe", src_addr, 32'h4000);

    // normal mode sweep: R2 R4 R5 R6 R7
    for (int c = 0; c < 16; c++) begin
      bit sz, si, di, m;
      sz = c[0]; si = c[1]; di = c[2]; m = c[3];
      step = sz ? 2 : 1;
      s0 = 32'h0080_1000 + c * 256;
      d0 = 32'h0020_0000 + c * 16;
      wr(3'd4, 32'd1);
      wr(3'd0, s0);
      wr(3'd1, d0);
      wr(3'd2, 32'd3);
      wr(3'd3, ctl(1, 0, sz, si, di, m));
      chk(busy, "R2 enable", {31'd0, busy}, 1);
      for (int k = 1; k <= 4; k++) begin
        stb();
        es = si ? s0 + k * step : s0;
        ed = di ? d0 + k * step : d0;
        chk(src_addr == es, "R4 src step", src_addr, es);
        chk(dst_addr == ed, "R4 dst step", dst_addr, ed);
        chk(xfer_count == 16'(3 - k), "R5 count", {16'd0, xfer_count}, 32'(16'(3 - k)));
        if (k < 4) chk(busy, "R5 still busy", {31'd0, busy}, 1);
      end
      chk(!busy, "R6 stop", {31'd0, busy}, 0);
      chk(irq_req == !m, "R7 irq vs mask", {31'd0, irq_req}, {31'd0, !m});
      stb();
      chk(src_addr == es && dst_addr == ed && xfer_count == 16'hFFFF, "R3 after end", src_addr, es);
    end
    // R7 clear while mask is set: mask does not hold the flag
    wr(3'd4, 32'd1);
    wr(3'd2, 32'd0);
    wr(3'd3, ctl(1, 0, 0, 0, 0, 0));
    stb();
    chk(irq_req, "R7 set", {31'd0, irq_req}, 1);
    wr(3'd3, ctl(0, 0, 0, 0, 0, 1));
    chk(irq_req, "R7 mask keeps pending flag", {31'd0, irq_req}, 1);
    wr(3'd4, 32'd1);
    chk(!irq_req, "R7 clear with mask", {31'd0, irq_req}, 0);

    // R10 completion and clear in same cycle
    wr(3'd2, 32'd0);
    wr(3'd3, ctl(1, 0, 0, 0, 0, 0));
    xfer_stb = 1'b1; wr_en = 1'b1; wr_sel = 3'd4; wr_data = 32'd1;
    cyc();
    xfer_stb = 1'b0; wr_en = 1'b0;
    chk(irq_req && !busy, "R10 set wins", {31'd0, irq_req}, 1);
    wr(3'd4, 32'd1);

    // R3 strobe blocked by a config write
    wr(3'd0, 32'h100);
    wr(3'd2, 32'd9);
    wr(3'd3, ctl(1, 0, 0, 1, 0, 0));
    xfer_stb = 1'b1; wr_en = 1'b1; wr_sel = 3'd2; wr_data = 32'd7;
    cyc();
    xfer_stb = 1'b0; wr_en = 1'b0;
    chk(xfer_count == 16'd7 && src_addr == 32'h100, "R3 write blocks strobe", {16'd0, xfer_count}, 7);
    wr(3'd3, ctl(0, 0, 0, 1, 0, 0));

    // ring sweep: R8 R9
    for (int c = 0; c < 8; c++) begin
      bit sz, si, di;
      sz = c[0]; si = c[1]; di = c[2];
      step = sz ? 2 : 1;
      s0 = 32'h0080_1000;
      d0 = 32'h0030_0000 + c * 64;
      wr(3'd0, s0);
      wr(3'd1, d0);
      wr(3'd2, 32'd5);
      wr(3'd3, ctl(1, 1, sz, si, di, 0));
      for (int k = 1; k <= 70; k++) begin
        stb();
        es = si ? s0 + (k % 32) * step : s0;
        ed = di ? d0 + (k % 32) * step : d0;
        chk(src_addr == es && dst_addr == ed, "R8 ring address", src_addr, es);
        chk(xfer_count == 16'(5 - k) && busy && !irq_req, "R8 ring count", {16'd0, xfer_count}, 32'(16'(5 - k)));
      end
      wr(3'd3, ctl(0, 1, sz, si, di, 0));
      chk(!busy && !irq_req, "R9 no irq on stop", {31'd0, irq_req}, 0);
    end

    // R5 full-length run: count left at FFFF, re-enable without reload
    wr(3'd0, 32'h0);
    wr(3'd2, 32'd0);
    wr(3'd3, ctl(1, 0, 0, 1, 0, 1));
    stb();
    chk(xfer_count == 16'hFFFF && !busy, "R5 end value", {16'd0, xfer_count}, 32'hFFFF);
    wr(3'd0, 32'h0);
    wr(3'd3, ctl(1, 0, 0, 1, 0, 1));
    ntx = 0;
    while (busy && ntx < 70000) begin
      stb();
      ntx++;
    end
    chk(ntx == 65536, "R5 65536 transfers", ntx, 65536);
    chk(src_addr == 32'h0001_0000, "R6 final address", src_addr, 32'h0001_0000);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule